// File: doc/BRIEF.md
# Routed level-interrupt controller

The block collects 256 level-sensitive interrupt lines and steers each one to one pin of one of four processor cores. Each core has eight pins. Software programs the block through a 32-bit register port. The inputs are handled in groups of 32. A pin selector is held per group and chooses the core pin. A core selector is held per input and chooses the core. An enable bitmap gates every input.

A core pin is a shared level. It is high while at least one enabled, pending input is steered to it. It falls only when the last of those inputs goes away. The block samples the lines into a raw status bitmap that software can read. A per-core status bank mirrors the enabled, pending inputs steered to that core, and software can clear its bits by writing ones. Every change to an enable, a selector or the selector format is reflected in the pins on the next clock. The block keeps no history, so the routing of pending inputs is always rebuilt from the raw status.

Two plain storage areas are kept for software and have no effect on routing: eight node-type words and eight bounce words. An external mode input switches both selectors from one-hot format to numeric format.

Top module: `xirq_router`

## Requirements
- R1: After reset every register reads zero, every core pin is low and the read data port is zero.
- R2: Registers are 32-bit words at aligned byte offsets. The read data appears one clock after the read strobe and is zero otherwise. Node-type (0x0A0–0x0BF), pin selector (0x0C0–0x0C7), enable (0x200–0x21F), bounce (0x280–0x29F) and core selector (0x800–0x8FF) read back what was written.
- R3: A write to an unmapped or misaligned offset changes nothing, and a read there returns zero. Writes to the raw status words (0x300–0x31F) are ignored.
- R4: Bit b of raw status word k (offset 0x300+4k) is input line 32k+b, sampled each clock. Enable, selector and status-bank writes never change it.
- R5: The pin selector for group g (inputs 32g..32g+31) is byte g%4 of the word at 0x0C0+4·(g/4), and only its low nibble is used. In one-hot format the lowest set bit of the nibble is the pin, and a zero nibble selects pin 0.
- R6: The core selector for input i is byte i%4 of the word at 0x800+4·(i/4), and only its low nibble is used. In one-hot format the lowest set bit is the core, and a zero nibble selects core 0.
- R7: With the mode input high, each nibble is a binary index for both selectors. An index at or above the core count (4) or the pin count (8) falls back to 0.
- R8: Output bit 8·core+pin is the OR of all enabled, pending inputs steered there. A shared pin stays high until every contributor is low.
- R9: Clearing an enable bit removes that input from the pins and status banks while its raw status bit stays set. Setting the bit again restores the contribution.
- R10: A change to either selector steers the inputs that are already pending to their new core and pin. The status banks are rebuilt from raw status and enables.
- R11: Bit b of the word at 0x400+0x100·core+4k reads as input 32k+b being enabled, pending and steered to that core. Writing a 1 clears the bit, and the pin, for one clock. The bit sets again on the next clock if the input is still pending. Bits written as 0 are unaffected.
- R12: A pin settles one clock after the raw status, enable, selector or mode change that moves it. It therefore settles two clocks after an input line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 256 | Level interrupt lines |
| map_numeric | input | 1 | Selector format: 0 one-hot, 1 binary index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one clock after the strobe |
| pin_out | output | 32 | Core pins, bit 8·core+pin |

## Verification
Every input is swept alone through selector bytes that cover all sixteen nibble values, in both formats. This catches a decoder that takes the highest set bit, misses the zero-nibble fallback or lets an out-of-range index through, because the pulse would then land on the wrong pin. Two inputs share one pin and are dropped one at a time. A design that lowers the pin on the first fall, as a per-input set/clear update would, shows up at once. An enable is cleared and set again while raw status is read back, and selectors are rewritten while an input is pending. A design that corrupts raw status or routes only on new edges would leave a stale pin high or keep the new one low. The clear-by-one write and the latency of each path are checked on the exact clock, so a missing or extra register stage is visible.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  // Byte offsets of the register areas inside the window
  localparam int unsigned OFS_NODE   = 32'h0A0;
  localparam int unsigned OFS_PMAP   = 32'h0C0;
  localparam int unsigned OFS_EN     = 32'h200;
  localparam int unsigned OFS_BNC    = 32'h280;
  localparam int unsigned OFS_RAW    = 32'h300;
  localparam int unsigned OFS_STA    = 32'h400;
  localparam int unsigned STA_STRIDE = 32'h100;
  localparam int unsigned OFS_CMAP   = 32'h800;
  localparam int unsigned NODE_WORDS = 8;

  // Turn a selector nibble into an index below count.
  // One-hot format: lowest set bit wins, none set gives 0.
  // Numeric format: the nibble itself, out of range gives 0.
  function automatic logic [3:0] map_pick(input logic [3:0] nib,
                                          input logic numeric,
                                          input int unsigned count);
    logic [3:0] r;
    r = 4'd0;
    if (numeric) begin
      if ({28'd0, nib} < count) r = nib;
    end else begin
      for (int k = 3; k >= 0; k--) begin
        if (nib[k]) r = 4'(k);
      end
      if ({28'd0, r} >= count) r = 4'd0;
    end
    return r;
  endfunction

  // Word address wa falls inside an area of words starting at byte base
  function automatic logic win_hit(input int unsigned wa,
                                   input int unsigned base,
                                   input int unsigned words);
    return (wa >= base / 4) && (wa < base / 4 + words);
  endfunction

endpackage

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned N_IN   = 256,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned GRP    = 32,
  parameter int unsigned AW     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [AW-1:0]            addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  input  logic [N_IN-1:0]          raw_q,
  input  logic [N_CORE*N_IN-1:0]   sta_q,
  output logic [N_IN-1:0]          en_out,
  output logic [(N_IN/GRP)*4-1:0]  pmap_nib,
  output logic [N_IN*4-1:0]        cmap_nib,
  output logic [N_CORE*N_IN-1:0]   clr_mask
);

  localparam int unsigned N_GRP  = N_IN / GRP;
  localparam int unsigned IN_W   = N_IN / 32;
  localparam int unsigned PMAP_W = (N_GRP + 3) / 4;
  localparam int unsigned CMAP_W = N_IN / 4;

  logic [NODE_WORDS*32-1:0] node_q;
  logic [IN_W*32-1:0]       bnc_q;
  logic [IN_W*32-1:0]       en_q;
  logic [PMAP_W*32-1:0]     pmap_q;
  logic [CMAP_W*32-1:0]     cmap_q;

  int unsigned wa;
  logic        aligned;
  logic        h_node, h_pmap, h_en, h_bnc, h_raw, h_cmap, h_store;
  logic [N_CORE-1:0] h_sta;
  int unsigned ix_node, ix_pmap, ix_en, ix_bnc, ix_raw, ix_cmap, ix_sta;
  logic [31:0] rd_val;
  logic        wr_noeffect;

  // Address decode and clear-by-one mask
  always_comb begin
    wa      = 32'(addr[AW-1:2]);
    aligned = (addr[1:0] == 2'b00);
    h_node  = aligned && win_hit(wa, OFS_NODE, NODE_WORDS);
    h_pmap  = aligned && win_hit(wa, OFS_PMAP, PMAP_W);
    h_en    = aligned && win_hit(wa, OFS_EN, IN_W);
    h_bnc   = aligned && win_hit(wa, OFS_BNC, IN_W);
    h_raw   = aligned && win_hit(wa, OFS_RAW, IN_W);
    h_cmap  = aligned && win_hit(wa, OFS_CMAP, CMAP_W);
    ix_node = wa - OFS_NODE / 4;
    ix_pmap = wa - OFS_PMAP / 4;
    ix_en   = wa - OFS_EN / 4;
    ix_bnc  = wa - OFS_BNC / 4;
    ix_raw  = wa - OFS_RAW / 4;
    ix_cmap = wa - OFS_CMAP / 4;
    ix_sta  = 0;
    clr_mask = '0;
    for (int unsigned c = 0; c < N_CORE; c++) begin
      h_sta[c] = aligned && win_hit(wa, OFS_STA + c * STA_STRIDE, IN_W);
      if (h_sta[c]) begin
        ix_sta = wa - (OFS_STA + c * STA_STRIDE) / 4;
        if (wr) clr_mask[c*N_IN + ix_sta*32 +: 32] = wdata;
      end
    end
    h_store     = h_node | h_pmap | h_en | h_bnc | h_cmap;
    wr_noeffect = wr && !h_store && !(|h_sta);
  end

  // Storage registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_q <= '0;
      bnc_q  <= '0;
      en_q   <= '0;
      pmap_q <= '0;
      cmap_q <= '0;
    end else if (wr) begin
      if (h_node) node_q[ix_node*32 +: 32] <= wdata;
      if (h_pmap) pmap_q[ix_pmap*32 +: 32] <= wdata;
      if (h_en)   en_q[ix_en*32 +: 32]     <= wdata;
      if (h_bnc)  bnc_q[ix_bnc*32 +: 32]   <= wdata;
      if (h_cmap) cmap_q[ix_cmap*32 +: 32] <= wdata;
    end
  end

  // Read multiplexer
  always_comb begin
    rd_val = '0;
    if (h_node) rd_val = node_q[ix_node*32 +: 32];
    if (h_pmap) rd_val = pmap_q[ix_pmap*32 +: 32];
    if (h_en)   rd_val = en_q[ix_en*32 +: 32];
    if (h_bnc)  rd_val = bnc_q[ix_bnc*32 +: 32];
    if (h_raw)  rd_val = raw_q[ix_raw*32 +: 32];
    if (h_cmap) rd_val = cmap_q[ix_cmap*32 +: 32];
    for (int unsigned c = 0; c < N_CORE; c++) begin
      if (h_sta[c]) rd_val = sta_q[c*N_IN + ix_sta*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? rd_val : 32'd0;
  end

  assign en_out = en_q;

  generate
    for (genvar g = 0; g < N_GRP; g++) begin : g_pnib
      assign pmap_nib[g*4 +: 4] = pmap_q[g*8 +: 4];
    end
    for (genvar i = 0; i < N_IN; i++) begin : g_cnib
      assign cmap_nib[i*4 +: 4] = cmap_q[i*8 +: 4];
    end
  endgenerate

  // R3: a write that hits no storage leaves all storage untouched
  a_r3_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_noeffect |=> ($stable(en_q) && $stable(pmap_q) && $stable(cmap_q)
                     && $stable(node_q) && $stable(bnc_q)));

  // R2: read data port is zero unless a read was strobed
  a_r2_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == 32'd0));

endmodule

// File: rtl/xirq_route.sv
module xirq_route
  import xirq_pkg::*;
#(
  parameter int unsigned N_IN   = 256,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_PIN  = 8,
  parameter int unsigned GRP    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          irq_in,
  input  logic                     numeric,
  input  logic [N_IN-1:0]          en_q,
  input  logic [(N_IN/GRP)*4-1:0]  pmap_nib,
  input  logic [N_IN*4-1:0]        cmap_nib,
  input  logic [N_CORE*N_IN-1:0]   clr_mask,
  output logic [N_IN-1:0]          raw_q,
  output logic [N_CORE*N_IN-1:0]   sta_q,
  output logic [N_CORE*N_PIN-1:0]  pin_q
);

  localparam int unsigned N_GRP = N_IN / GRP;
  localparam int unsigned CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1;
  localparam int unsigned PW    = (N_PIN > 1) ? $clog2(N_PIN) : 1;

  logic [CW-1:0]             core_sel [N_IN];
  logic [PW-1:0]             pin_sel  [N_GRP];
  logic [N_IN-1:0]           lvl;
  logic [N_CORE*N_IN-1:0]    sta_d;
  logic [N_CORE*N_GRP-1:0]   grp_any;
  logic [N_CORE*N_PIN-1:0]   pin_d;

  // Selector decode
  always_comb begin
    for (int unsigned i = 0; i < N_IN; i++)
      core_sel[i] = CW'(map_pick(cmap_nib[i*4 +: 4], numeric, N_CORE));
    for (int unsigned g = 0; g < N_GRP; g++)
      pin_sel[g] = PW'(map_pick(pmap_nib[g*4 +: 4], numeric, N_PIN));
  end

  assign lvl = raw_q & en_q;

  // Status banks: enabled pending inputs steered to each core,
  // minus the bits software is clearing this cycle
  always_comb begin
    for (int unsigned c = 0; c < N_CORE; c++)
      for (int unsigned i = 0; i < N_IN; i++)
        sta_d[c*N_IN + i] = lvl[i] && (core_sel[i] == CW'(c))
                            && !clr_mask[c*N_IN + i];
  end

  // Pin levels: OR of each group's bank bits onto the group's pin
  always_comb begin
    pin_d = '0;
    for (int unsigned c = 0; c < N_CORE; c++) begin
      for (int unsigned g = 0; g < N_GRP; g++) begin
        grp_any[c*N_GRP + g] = |sta_d[c*N_IN + g*GRP +: GRP];
        if (grp_any[c*N_GRP + g]) pin_d[c*N_PIN + 32'(pin_sel[g])] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      sta_q <= '0;
      pin_q <= '0;
    end else begin
      raw_q <= irq_in;
      sta_q <= sta_d;
      pin_q <= pin_d;
    end
  end

  generate
    for (genvar c = 0; c < N_CORE; c++) begin : g_chk
      // R8: a core has a pin up exactly when its bank holds a bit
      a_r8_pin_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_q[c*N_PIN +: N_PIN]) == (|sta_q[c*N_IN +: N_IN]));
      // R9: bank bits only for inputs that were enabled and pending
      a_r9_bank_within_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sta_q[c*N_IN +: N_IN] & ~$past(lvl)) == '0));
      // R11: bits written as one are clear on the following clock
      a_r11_clear_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sta_q[c*N_IN +: N_IN] & $past(clr_mask[c*N_IN +: N_IN])) == '0));
      for (genvar d = c + 1; d < N_CORE; d++) begin : g_pair
        // R6: an input is steered to one core only
        a_r6_one_core: assert property (@(posedge clk) disable iff (!rst_n)
          (sta_q[c*N_IN +: N_IN] & sta_q[d*N_IN +: N_IN]) == '0);
      end
    end
  endgenerate

endmodule

// File: rtl/xirq_router.sv
module xirq_router
  import xirq_pkg::*;
#(
  parameter int unsigned N_IN   = 256,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_PIN  = 8,
  parameter int unsigned GRP    = 32,
  parameter int unsigned AW     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         irq_in,
  input  logic                    map_numeric,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [AW-1:0]           reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic [N_CORE*N_PIN-1:0] pin_out
);

  localparam int unsigned N_GRP = N_IN / GRP;

  logic [N_IN-1:0]        raw_q;
  logic [N_CORE*N_IN-1:0] sta_q;
  logic [N_IN-1:0]        en_q;
  logic [N_GRP*4-1:0]     pmap_nib;
  logic [N_IN*4-1:0]      cmap_nib;
  logic [N_CORE*N_IN-1:0] clr_mask;

  xirq_regs #(.N_IN(N_IN), .N_CORE(N_CORE), .GRP(GRP), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .raw_q    (raw_q),
    .sta_q    (sta_q),
    .en_out   (en_q),
    .pmap_nib (pmap_nib),
    .cmap_nib (cmap_nib),
    .clr_mask (clr_mask)
  );

  xirq_route #(.N_IN(N_IN), .N_CORE(N_CORE), .N_PIN(N_PIN), .GRP(GRP)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .numeric  (map_numeric),
    .en_q     (en_q),
    .pmap_nib (pmap_nib),
    .cmap_nib (cmap_nib),
    .clr_mask (clr_mask),
    .raw_q    (raw_q),
    .sta_q    (sta_q),
    .pin_q    (pin_out)
  );

endmodule

// File: tb/xirq_router_tb.sv
`timescale 1ns/1ps
module xirq_router_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] irq = '0;
  logic         numeric = 1'b0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [31:0]  pins;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0]   cmap_s [256];
  logic [7:0]   pmap_s [8];
  logic [255:0] en_s;

  always #2.5 clk = ~clk;

  xirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .map_numeric(numeric),
    .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .pin_out(pins)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Selector decode, restated as a priority match
  function automatic int pick(input logic [3:0] nib, input logic num, input int cnt);
    int r;
    if (num) r = (int'(nib) < cnt) ? int'(nib) : 0;
    else begin
      casez (nib)
        4'b???1: r = 0;
        4'b??10: r = 1;
        4'b?100: r = 2;
        4'b1000: r = 3;
        default: r = 0;
      endcase
      if (r >= cnt) r = 0;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_pins(input logic [255:0] lines);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 256; i++) begin
      if (lines[i] && en_s[i])
        r[pick(cmap_s[i][3:0], numeric, 4) * 8 + pick(pmap_s[i/32][3:0], numeric, 8)] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic push_cmap(input int w);
    wr32(12'h800 + 12'(4*w), {cmap_s[4*w+3], cmap_s[4*w+2], cmap_s[4*w+1], cmap_s[4*w]});
  endtask

  task automatic push_all();
    for (int w = 0; w < 64; w++) push_cmap(w);
    for (int w = 0; w < 2; w++)
      wr32(12'h0C0 + 12'(4*w), {pmap_s[4*w+3], pmap_s[4*w+2], pmap_s[4*w+1], pmap_s[4*w]});
    for (int w = 0; w < 8; w++) wr32(12'h200 + 12'(4*w), en_s[32*w +: 32]);
  endtask

  task automatic push_pmap0();
    wr32(12'h0C0, {pmap_s[3], pmap_s[2], pmap_s[1], pmap_s[0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] seed;
    logic [255:0] pat;

    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);

    // R1: reset state
    chk("R1 pins after reset", pins, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    rd32(12'h200, d); chk("R1 enable word", d, 32'h0);
    rd32(12'h800, d); chk("R1 core selector word", d, 32'h0);
    rd32(12'h0C0, d); chk("R1 pin selector word", d, 32'h0);
    rd32(12'h0A0, d); chk("R1 node-type word", d, 32'h0);
    rd32(12'h300, d); chk("R1 raw status word", d, 32'h0);
    chk("R2 rdata zero after read", rdata, 32'h0);

    // R2: storage readback
    for (int k = 0; k < 8; k++) wr32(12'h0A0 + 12'(4*k), 32'hA500_0000 + k);
    for (int k = 0; k < 8; k++) wr32(12'h280 + 12'(4*k), 32'h5A00_1000 + k);
    for (int k = 0; k < 8; k++) begin
      rd32(12'h0A0 + 12'(4*k), d); chk("R2 node-type readback", d, 32'hA500_0000 + k);
      rd32(12'h280 + 12'(4*k), d); chk("R2 bounce readback", d, 32'h5A00_1000 + k);
    end
    for (int k = 0; k < 64; k++) wr32(12'h800 + 12'(4*k), 32'h0102_0304 * (k + 1));
    for (int k = 0; k < 64; k++) begin
      rd32(12'h800 + 12'(4*k), d); chk("R2 core selector readback", d, 32'h0102_0304 * (k + 1));
    end
    wr32(12'h0C4, 32'hDEAD_BEEF); rd32(12'h0C4, d); chk("R2 pin selector readback", d, 32'hDEAD_BEEF);
    wr32(12'h21C, 32'h1234_5678); rd32(12'h21C, d); chk("R2 enable readback", d, 32'h1234_5678);

    // R3: unmapped, misaligned and raw-status writes
    wr32(12'h000, 32'hFFFF_FFFF);
    wr32(12'h0C8, 32'hFFFF_FFFF);
    wr32(12'h220, 32'hFFFF_FFFF);
    wr32(12'h900, 32'hFFFF_FFFF);
    wr32(12'h21D, 32'hFFFF_FFFF);
    wr32(12'h300, 32'hFFFF_FFFF);
    rd32(12'h000, d); chk("R3 unmapped read 0x000", d, 32'h0);
    rd32(12'h0C8, d); chk("R3 unmapped read 0x0C8", d, 32'h0);
    rd32(12'h900, d); chk("R3 unmapped read 0x900", d, 32'h0);
    rd32(12'h21C, d); chk("R3 misaligned write ignored", d, 32'h1234_5678);
    rd32(12'h300, d); chk("R3 raw status not writable", d, 32'h0);
    rd32(12'h8FC, d); chk("R3 core selector untouched", d, 32'h0102_0304 * 64);

    // R5 R6: single-input sweep, one-hot format
    for (int i = 0; i < 256; i++) cmap_s[i] = 8'((i * 5 + 3) & 15) | 8'hA0;
    for (int g = 0; g < 8; g++) pmap_s[g] = 8'((g * 3) & 15) | 8'h50;
    en_s = '1;
    push_all();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); irq = '0; irq[i] = 1'b1;
      wait_n(2);
      chk("R5 R6 one-hot sweep", pins, exp_pins(irq));
    end
    // R7: same sweep, numeric format
    numeric = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); irq = '0; irq[i] = 1'b1;
      wait_n(2);
      chk("R7 numeric sweep", pins, exp_pins(irq));
    end

    // R8: multi-input patterns with mixed enables and selectors
    seed = 32'h1BAD_F00D;
    for (int t = 0; t < 24; t++) begin
      numeric = t[0];
      for (int i = 0; i < 256; i++) begin seed = xs(seed); cmap_s[i] = seed[7:0]; end
      for (int g = 0; g < 8; g++) begin seed = xs(seed); pmap_s[g] = seed[15:8]; end
      for (int w = 0; w < 8; w++) begin seed = xs(seed); en_s[32*w +: 32] = seed; end
      for (int w = 0; w < 8; w++) begin seed = xs(seed); pat[32*w +: 32] = seed & xs(seed + 1); end
      push_all();
      @(negedge clk); irq = pat;
      wait_n(2);
      chk("R8 pattern", pins, exp_pins(irq));
      rd32(12'h304, d); chk("R4 raw status word", d, pat[63:32]);
    end

    // R8: shared pin, core 2 pin 1, inputs 3 and 40
    numeric = 1'b0;
    for (int i = 0; i < 256; i++) cmap_s[i] = 8'h00;
    for (int g = 0; g < 8; g++) pmap_s[g] = 8'h00;
    en_s = '1;
    cmap_s[3] = 8'h04; cmap_s[40] = 8'h04;
    pmap_s[0] = 8'h02; pmap_s[1] = 8'h02;
    @(negedge clk); irq = '0;
    push_all();
    @(negedge clk); irq[3] = 1'b1; irq[40] = 1'b1;
    wait_n(2); chk("R8 shared pin high", pins, 32'h1 << 17);
    @(negedge clk); irq[3] = 1'b0;
    wait_n(2); chk("R8 shared pin held by one", pins, 32'h1 << 17);
    @(negedge clk); irq[40] = 1'b0;
    wait_n(2); chk("R8 shared pin low", pins, 32'h0);

    // R9: enable clear and restore
    @(negedge clk); irq[40] = 1'b1;
    wait_n(2); chk("R9 pin before disable", pins, 32'h1 << 17);
    en_s[40] = 1'b0; wr32(12'h204, en_s[63:32]);
    wait_n(1); chk("R9 pin after disable", pins, 32'h0);
    rd32(12'h304, d); chk("R9 raw status kept", d, 32'h1 << 8);
    en_s[40] = 1'b1; wr32(12'h204, en_s[63:32]);
    wait_n(1); chk("R9 pin after re-enable", pins, 32'h1 << 17);

    // R10: selector changes while pending
    cmap_s[40] = 8'h02; push_cmap(10);
    wait_n(1); chk("R10 moved to core 1", pins, 32'h1 << 9);
    rd32(12'h504, d); chk("R10 core 1 bank", d, 32'h1 << 8);
    rd32(12'h604, d); chk("R10 core 2 bank empty", d, 32'h0);
    pmap_s[1] = 8'h08; push_pmap0();
    wait_n(1); chk("R10 moved to pin 3", pins, 32'h1 << 11);

    // R11: clear by writing one
    wr32(12'h504, 32'h0);
    chk("R11 zero write no effect", pins, 32'h1 << 11);
    wr32(12'h504, 32'h1 << 8);
    chk("R11 cleared for one clock", pins, 32'h0);
    wait_n(1); chk("R11 re-asserts while pending", pins, 32'h1 << 11);
    rd32(12'h504, d); chk("R11 bank bit back", d, 32'h1 << 8);

    // R12: latency
    @(negedge clk); irq[40] = 1'b0;
    wait_n(1); chk("R12 pin one clock after line", pins, 32'h1 << 11);
    wait_n(1); chk("R12 pin two clocks after line", pins, 32'h0);
    @(negedge clk); irq[40] = 1'b1;
    wait_n(2);
    en_s[40] = 1'b0; wr32(12'h204, en_s[63:32]);
    chk("R12 pin unchanged at enable write", pins, 32'h1 << 11);
    wait_n(1); chk("R12 pin one clock after enable", pins, 32'h0);

    // R7: explicit numeric indices and fallback
    en_s[40] = 1'b1; wr32(12'h204, en_s[63:32]);
    numeric = 1'b1;
    cmap_s[40] = 8'h03; pmap_s[1] = 8'h07; push_cmap(10); push_pmap0();
    wait_n(1); chk("R7 core 3 pin 7", pins, 32'h1 << 31);
    cmap_s[40] = 8'h05; pmap_s[1] = 8'h09; push_cmap(10); push_pmap0();
    wait_n(1); chk("R7 out-of-range fallback", pins, 32'h1);
    rd32(12'h300 + 12'h4, d); chk("R4 raw unaffected by map writes", d, 32'h1 << 8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule